// File: doc/BRIEF.md
# Flash Write Status Polling Generator

This block sits beside a flash bank controller and produces what the host sees when it reads the bank while an embedded program or erase is running. It keeps the target address and the most significant bit of the word being programmed, and it answers reads with a status word. The top bit of that status word is the polling bit. Bits below it are placeholders for the toggle and error flags and always read zero. A separate ready/busy output is low while an operation is under way.

A one-cycle `cmd_valid` pulse stands for the rising edge of the final write pulse of a command sequence, and polling is valid from the next cycle. The bank controller reports the end of an operation with `op_done` and the entry into erase suspend with `susp_req`.

A program aimed at a protected sector is not sent to the controller. The block shows busy for a fixed window of about 1 µs, counted in clock cycles from a clock-frequency parameter, and then returns to read mode by itself without changing the array. Reads that do not hit the active operation return data from a small register-file stand-in for the array. The stand-in is written when a program completes, and the erased address is filled with all ones when an erase completes.

Top module: `wsp_top`

## Requirements
- R1: After a synchronous reset, `rdy` is 1 and `rd_valid` is 0.
- R2: A `cmd_valid` accepted while `rdy` is 1 drives `rdy` to 0 from the following cycle.
- R3: While a program is running, a read at the program address returns a status word. Its top bit (bit DW-1) is the complement of the top bit of the programmed datum, and all other bits are 0.
- R4: While a program is running, a read at any other address returns the stored array word.
- R5: `op_done` during a program or erase raises `rdy` in the next cycle. From that cycle on, a read at the program address returns the full programmed datum.
- R6: A program with `sect_prot`=1 holds `rdy` at 0 for exactly PROT_CYC cycles, where PROT_CYC is (CLK_HZ/1e6)*PROT_NS/1000. That is 50 cycles at the default 50 MHz and 1000 ns. During the window, reads at the address return complement status. Afterwards `rdy` is 1 and the array word at that address is unchanged.
- R7: While an erase is running, every read returns an all-zero status word.
- R8: `susp_req` during an erase sets `rdy` to 1 in the next cycle. Reads at the erase address then return a status word with only the top bit set, and reads at other addresses return array data.
- R9: A program started during erase suspend behaves as in R3. When it completes, the block returns to suspend, so R8 reads apply again and the programmed word is stored.
- R10: An erase command (`cmd_kind`=1) issued during suspend resumes the erase at the stored erase address. When the erase completes, that address reads all ones.
- R11: `cmd_valid` while `rdy` is 0 is ignored. The target address and datum of the running program stay as they were, and no extra write reaches the array.
- R12: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en`=1, and `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Final write of a command sequence |
| cmd_kind | input | 1 | 0 = program, 1 = erase / erase resume |
| cmd_addr | input | AW | Program or erase address |
| cmd_data | input | DW | Datum to program |
| sect_prot | input | 1 | Target sector is protected |
| op_done | input | 1 | Controller reports completion |
| susp_req | input | 1 | Controller reports entry into erase suspend |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| rd_data | output | DW | Read result (status or array word) |
| rd_valid | output | 1 | `rd_data` is valid |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions assume the following about the controller's inputs:
- `op_done` and `susp_req` are single-cycle pulses.
- `susp_req` comes only while an erase runs.
- During a protected-sector window `op_done` stays low, because the controller never receives that operation.

The stimulus follows these rules. It drives every input on the falling edge as a one-cycle pulse, and it raises `op_done` or `susp_req` only in the state where the controller would. It never reads an array address in the same cycle that the address is written. Every address it reads back as array data has been programmed first, so no check depends on uninitialised storage.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_PROT  = 3'd2,
    ST_ERASE = 3'd3,
    ST_ESUSP = 3'd4
  } wsp_state_e;

  localparam logic OP_PROG  = 1'b0;
  localparam logic OP_ERASE = 1'b1;
endpackage

// File: rtl/wsp_seq.sv
module wsp_seq
  import wsp_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int PROT_CYC = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          sect_prot,
  input  logic          op_done,
  input  logic          susp_req,
  output wsp_state_e    st,
  output logic [AW-1:0] paddr,
  output logic          pbit,
  output logic [AW-1:0] eaddr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rdy
);
  localparam int TW = (PROT_CYC < 2) ? 1 : $clog2(PROT_CYC);

  logic [DW-1:0] pdata;
  logic [TW-1:0] tmr;
  logic          insusp;

  assign pbit    = pdata[DW-1];
  assign wr_en   = op_done && (st == ST_PROG || st == ST_ERASE);
  assign wr_addr = (st == ST_PROG) ? paddr : eaddr;
  assign wr_data = (st == ST_PROG) ? pdata : {DW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      paddr  <= '0;
      pdata  <= '0;
      eaddr  <= '0;
      tmr    <= '0;
      insusp <= 1'b0;
      rdy    <= 1'b1;
    end else begin
      case (st)
        ST_IDLE, ST_ESUSP: begin
          if (cmd_valid) begin
            rdy <= 1'b0;
            if (cmd_kind == OP_PROG) begin
              paddr  <= cmd_addr;
              pdata  <= cmd_data;
              insusp <= (st == ST_ESUSP);
              tmr    <= TW'(PROT_CYC - 1);
              st     <= sect_prot ? ST_PROT : ST_PROG;
            end else begin
              // a resume keeps the stored erase address
              if (st == ST_IDLE) eaddr <= cmd_addr;
              st <= ST_ERASE;
            end
          end
        end
        ST_PROG: begin
          if (op_done) begin
            st  <= insusp ? ST_ESUSP : ST_IDLE;
            rdy <= 1'b1;
          end
        end
        ST_PROT: begin
          if (tmr == '0) begin
            st  <= insusp ? ST_ESUSP : ST_IDLE;
            rdy <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_ERASE: begin
          if (op_done) begin
            st  <= ST_IDLE;
            rdy <= 1'b1;
          end else if (susp_req) begin
            st  <= ST_ESUSP;
            rdy <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsp_array.sv
module wsp_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/wsp_rdmux.sv
module wsp_rdmux
  import wsp_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  wsp_state_e    st,
  input  logic [AW-1:0] paddr,
  input  logic          pbit,
  input  logic [AW-1:0] eaddr,
  input  logic [DW-1:0] mem_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic          hit;
  logic          poll;
  logic          sel_q;
  logic [DW-1:0] stat_q;

  always_comb begin
    hit  = 1'b0;
    poll = 1'b0;
    case (st)
      ST_PROG, ST_PROT: begin
        hit  = (rd_addr == paddr);
        poll = ~pbit;
      end
      ST_ERASE: begin
        hit  = 1'b1;
        poll = 1'b0;
      end
      ST_ESUSP: begin
        hit  = (rd_addr == eaddr);
        poll = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      stat_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_q  <= hit;
        // toggle and error placeholders stay zero
        stat_q <= {poll, {(DW-1){1'b0}}};
      end
    end
  end

  assign rd_data = sel_q ? stat_q : mem_q;
endmodule

// File: rtl/wsp_top.sv
module wsp_top
  import wsp_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 8,
  parameter int CLK_HZ  = 50_000_000,
  parameter int PROT_NS = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          sect_prot,
  input  logic          op_done,
  input  logic          susp_req,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rdy
);
  localparam int PROT_RAW = (CLK_HZ / 1_000_000) * PROT_NS / 1000;
  localparam int PROT_CYC = (PROT_RAW < 1) ? 1 : PROT_RAW;

  wsp_state_e    st_w;
  logic [AW-1:0] paddr_w, eaddr_w, wa_w;
  logic          pbit_w, we_w;
  logic [DW-1:0] wd_w, memq_w;

  wsp_seq #(.AW(AW), .DW(DW), .PROT_CYC(PROT_CYC)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sect_prot(sect_prot),
    .op_done(op_done), .susp_req(susp_req), .st(st_w), .paddr(paddr_w),
    .pbit(pbit_w), .eaddr(eaddr_w), .wr_en(we_w), .wr_addr(wa_w),
    .wr_data(wd_w), .rdy(rdy)
  );

  wsp_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(we_w), .wa(wa_w), .wd(wd_w),
    .re(rd_en), .ra(rd_addr), .q(memq_w)
  );

  wsp_rdmux #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .st(st_w),
    .paddr(paddr_w), .pbit(pbit_w), .eaddr(eaddr_w), .mem_q(memq_w),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/wsp_chk.sv
module wsp_chk
  import wsp_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int PROT_CYC = 50
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_kind,
  input logic          sect_prot,
  input logic          op_done,
  input logic          susp_req,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rdy,
  input wsp_state_e    st,
  input logic [AW-1:0] paddr,
  input logic          pbit
);
  localparam int CW = $clog2(PROT_CYC + 2);
  logic [CW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) pcnt <= '0;
    else if (rdy && cmd_valid && cmd_kind == OP_PROG && sect_prot) pcnt <= CW'(1);
    else if (pcnt != '0 && pcnt < CW'(PROT_CYC)) pcnt <= pcnt + 1'b1;
    else pcnt <= '0;
  end

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rdy && cmd_valid |=> !rdy); // R2
  AST_PROG_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG || st == ST_PROT) && rd_en && rd_addr == paddr
    |=> rd_data[DW-1] == !pbit); // R3
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG || st == ST_ERASE) && op_done |=> rdy); // R5
  AST_PROT_BUSY: assert property (@(posedge clk) disable iff (rst)
    pcnt != '0 |-> !rdy); // R6
  AST_PROT_END: assert property (@(posedge clk) disable iff (rst)
    pcnt == CW'(PROT_CYC) |=> rdy); // R6
  AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    st == ST_ERASE && rd_en |=> rd_data == '0); // R7
  AST_SUSP_READY: assert property (@(posedge clk) disable iff (rst)
    st == ST_ERASE && susp_req && !op_done |=> rdy); // R8
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R12
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R12
endmodule

bind wsp_top wsp_chk #(.AW(AW), .DW(DW), .PROT_CYC(PROT_CYC)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .sect_prot(sect_prot), .op_done(op_done), .susp_req(susp_req),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .rdy(rdy), .st(st_w), .paddr(paddr_w), .pbit(pbit_w)
);

// File: tb/sim_wsp_top.sv
`timescale 1ns/1ps
module sim_wsp_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int EXP_PROT = 50; // 50 MHz * 1 us

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_kind = 1'b0, sect_prot = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          op_done = 1'b0, susp_req = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rdy;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  wsp_top u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sect_prot(sect_prot),
    .op_done(op_done), .susp_req(susp_req), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .rdy(rdy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12 actual=unexpected_read expected=none");
      end else begin
        chk(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic cmd(input logic kind, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic prot);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_addr = a; cmd_data = d; sect_prot = prot;
    @(negedge clk);
    cmd_valid = 1'b0; sect_prot = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdy", int'(rdy), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);

    // first program: addr 9, datum 3C -> poll bit 1
    cmd(1'b0, 6'd9, 8'h3C, 1'b0);
    chk("R2 busy", int'(rdy), 0);
    rd(6'd9, 8'h80, "R3 prog 3C");
    chk("R12 valid", int'(rd_valid), 1);
    @(negedge clk);
    chk("R12 quiet", int'(rd_valid), 0);
    done_pulse();
    chk("R5 rdy", int'(rdy), 1);
    rd(6'd9, 8'h3C, "R5 data 3C");

    // second program: addr 5, datum A5 -> poll bit 0
    cmd(1'b0, 6'd5, 8'hA5, 1'b0);
    chk("R2 busy2", int'(rdy), 0);
    rd(6'd5, 8'h00, "R3 prog A5");
    rd(6'd9, 8'h3C, "R4 other addr");
    cmd(1'b0, 6'd9, 8'h11, 1'b0); // ignored
    chk("R11 still busy", int'(rdy), 0);
    rd(6'd5, 8'h00, "R11 target kept");
    done_pulse();
    chk("R5 rdy2", int'(rdy), 1);
    rd(6'd5, 8'hA5, "R5 data A5");
    rd(6'd9, 8'h3C, "R11 no stray write");

    // protected program at addr 9, datum 7E
    cmd(1'b0, 6'd9, 8'h7E, 1'b1);
    chk("R6 busy", int'(rdy), 0);
    rd(6'd9, 8'h80, "R6 fake status");
    cnt = 1;
    while (!rdy) begin
      cnt++;
      @(negedge clk);
    end
    chk("R6 window", cnt, EXP_PROT);
    rd(6'd9, 8'h3C, "R6 array unchanged");

    // erase at addr 20
    cmd(1'b1, 6'd20, 8'h00, 1'b0);
    chk("R2 erase busy", int'(rdy), 0);
    rd(6'd20, 8'h00, "R7 erase addr");
    rd(6'd5, 8'h00, "R7 other addr");
    susp_req = 1'b1;
    @(negedge clk);
    susp_req = 1'b0;
    chk("R8 rdy", int'(rdy), 1);
    rd(6'd20, 8'h80, "R8 susp status");
    rd(6'd5, 8'hA5, "R8 array");

    // program during suspend
    cmd(1'b0, 6'd30, 8'h01, 1'b0);
    chk("R9 busy", int'(rdy), 0);
    rd(6'd30, 8'h80, "R9 prog status");
    done_pulse();
    chk("R9 rdy", int'(rdy), 1);
    rd(6'd20, 8'h80, "R9 back in suspend");
    rd(6'd30, 8'h01, "R9 data");

    // resume and finish erase
    cmd(1'b1, 6'd20, 8'h00, 1'b0);
    chk("R10 busy", int'(rdy), 0);
    rd(6'd20, 8'h00, "R10 erasing");
    rd(6'd30, 8'h00, "R10 any addr");
    done_pulse();
    chk("R10 rdy", int'(rdy), 1);
    rd(6'd20, 8'hFF, "R10 erased word");
    rd(6'd30, 8'h01, "R10 other kept");

    repeat (3) @(negedge clk);
    chk("R12 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule